// File: doc/BRIEF.md
# Lockable Watchdog Timer

This block is a 16-bit timer with two personalities. In timer mode it counts up or down on a prescaled 32 kHz tick and raises an interrupt whenever it wraps. Software can pick a free-running wrap or a periodic reload from the load register. In watchdog mode it counts down from the load value. If software fails to service it in time, the expiry raises either an interrupt or a system reset request, as chosen by a control bit.

Software reaches the block through a small register port with four word addresses: 0 load, 1 value (read-only), 2 control and 3 clear. A write of any data to the clear address services the watchdog. Once watchdog mode has been entered, the load and control registers are frozen, and only the synchronous system reset `rst` brings the block back to timer mode. The `tick_in` input is a one-cycle strobe per period of the slow reference clock. Generating that strobe and distributing the reset request are outside this block.

Control register fields:
- bit 0: count up in timer mode.
- bit 1: reset-select for watchdog expiry.
- bits 3:2: prescale select.
- bit 4: timer enable.
- bit 5: watchdog mode.
- bit 6: periodic reload.

Top module: `lockwd_timer`

## Requirements
- R1: After `rst` the load register reads 0xFFFF, the value reads 0, the control register reads 0, and `irq` and `rst_req` are low.
- R2: The counter advances once per 1, 16 or 256 `tick_in` pulses, for control bits 3:2 equal to 00, 01 or 10/11 respectively. The prescaler restarts from zero whenever the counter is reloaded (load write in timer mode, watchdog entry, clear write).
- R3: In timer mode (bit 5 clear) the counter moves only while bit 4 is set, and a load write copies the written data into the counter. Counting down (bit 0 clear), a step taken at 0 goes to the load value if bit 6 is set, otherwise to 0xFFFF. Counting up, a step taken at 0xFFFF goes to the load value if bit 6 is set, otherwise to 0. Both wraps set `irq`.
- R4: A control write with bit 5 set enters watchdog mode, copies the current load value into the counter, and from then on the counter decrements by one per prescaled step regardless of bit 4.
- R5: In watchdog mode a prescaled step taken while the counter is 0 is an expiry, so expiry comes load+1 steps after a reload. With bit 1 clear, an expiry sets `irq` and the counter reloads from the load register and keeps counting. With bit 1 set, an expiry raises `rst_req` and leaves `irq` unchanged. `rst_req` then stays high and the counter stays frozen until `rst`.
- R6: A write of any data to address 3 reloads the counter from the load register, restarts the prescaler and clears `irq`. If it falls in the same cycle as an expiry step, the clear wins and no expiry happens.
- R7: While in watchdog mode, writes to the load and control addresses are ignored; only `rst` clears bit 5.
- R8: Writes to the value address 1 have no effect.
- R9: `rd_data` returns the register selected by `rd_addr` one clock later. Control reads as bits 6:0 with zeros above, and the clear address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high system reset |
| tick_in | input | 1 | One-cycle strobe per 32 kHz period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 load, 1 value, 2 control, 3 clear) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Registered read data |
| irq | output | 1 | Pending interrupt, cleared by a clear write |
| rst_req | output | 1 | Reset request, held until `rst` |

## Verification
The coincidence of interest is a service write to the clear address landing in the very cycle that the watchdog counter, sitting at zero, receives its expiry step. The bench walks the counter down to zero with single-tick steps. It then drives `tick_in` and the clear write together in one cycle and expects `irq` to stay low with the counter back at the load value. A full new period of load+1 steps must then pass before `irq` rises. A design that lets expiry win, or that reloads without restarting the prescaler, misses either the low `irq` or the exact step count.

// File: rtl/lockwd_pkg.sv
package lockwd_pkg;
  localparam logic [1:0] ADDR_LOAD  = 2'd0;
  localparam logic [1:0] ADDR_VALUE = 2'd1;
  localparam logic [1:0] ADDR_CTRL  = 2'd2;
  localparam logic [1:0] ADDR_CLEAR = 2'd3;
  localparam int CTRL_W = 7;

  // bit 6 periodic, bit 5 watchdog, bit 4 enable, 3:2 prescale, bit 1 reset-select, bit 0 up
  typedef struct packed {
    logic       periodic;
    logic       wd;
    logic       en;
    logic [1:0] psel;
    logic       rsel;
    logic       up;
  } ctrl_t;
endpackage

// File: rtl/lockwd_prescale.sv
module lockwd_prescale #(
  parameter int PRE_W  = 8,
  parameter int MID_SH = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_in,
  input  logic       restart,
  input  logic [1:0] psel,
  output logic       ptick
);
  localparam logic [PRE_W-1:0] LAST_MID = PRE_W'((1 << MID_SH) - 1);
  localparam logic [PRE_W-1:0] LAST_MAX = {PRE_W{1'b1}};

  logic [PRE_W-1:0] pcnt;
  logic [PRE_W-1:0] last;
  logic             at_last;

  always_comb begin
    case (psel)
      2'b00:   last = '0;
      2'b01:   last = LAST_MID;
      default: last = LAST_MAX;
    endcase
  end

  assign at_last = (pcnt >= last);
  assign ptick   = tick_in && !restart && at_last;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pcnt <= '0;
    end else if (tick_in) begin
      pcnt <= at_last ? '0 : pcnt + 1'b1;
    end
  end

  AST_PTICK_WRAPS: assert property (@(posedge clk) disable iff (rst)
    ptick |=> (pcnt == '0)); // R2

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
    restart |=> (pcnt == '0) && !ptick || tick_in); // R2
endmodule

// File: rtl/lockwd_regs.sv
module lockwd_regs
  import lockwd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  input  logic [CNT_W-1:0] cnt_val,
  output logic [CNT_W-1:0] load_q,
  output ctrl_t            ctrl_q,
  output logic [CNT_W-1:0] rd_data,
  output logic             load_wr,
  output logic             wd_enter,
  output logic             clr_wr
);
  logic locked;
  logic ctrl_wr;

  assign locked   = ctrl_q.wd;
  assign load_wr  = wr_en && (wr_addr == ADDR_LOAD) && !locked;
  assign ctrl_wr  = wr_en && (wr_addr == ADDR_CTRL) && !locked;
  assign wd_enter = ctrl_wr && wr_data[5];
  assign clr_wr   = wr_en && (wr_addr == ADDR_CLEAR);

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q <= '1;
      ctrl_q <= '0;
    end else begin
      if (load_wr) load_q <= wr_data;
      if (ctrl_wr) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        ADDR_LOAD:  rd_data <= load_q;
        ADDR_VALUE: rd_data <= cnt_val;
        ADDR_CTRL:  rd_data <= CNT_W'(ctrl_q);
        default:    rd_data <= '0;
      endcase
    end
  end

  AST_LOCK_LOAD: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.wd && wr_en && wr_addr == ADDR_LOAD) |=> (load_q == $past(load_q))); // R7

  AST_LOCK_CTRL: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.wd && wr_en && wr_addr == ADDR_CTRL) |=> (ctrl_q == $past(ctrl_q))); // R7

  AST_WD_STICKY: assert property (@(posedge clk) disable iff (rst)
    ctrl_q.wd |=> ctrl_q.wd); // R7
endmodule

// File: rtl/lockwd_counter.sv
module lockwd_counter
  import lockwd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ptick,
  input  logic             reload,
  input  logic [CNT_W-1:0] reload_val,
  input  logic [CNT_W-1:0] load_q,
  input  ctrl_t            ctrl,
  input  logic             freeze,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap_evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             running;
  logic             at_end;
  logic [CNT_W-1:0] cnt_nxt;

  assign running = ctrl.wd || ctrl.en;
  assign at_end  = (!ctrl.wd && ctrl.up) ? (cnt_q == CNT_MAX) : (cnt_q == '0);

  always_comb begin
    wrap_evt = 1'b0;
    cnt_nxt  = cnt_q;
    if (freeze) begin
      cnt_nxt = cnt_q;
    end else if (reload) begin
      cnt_nxt = reload_val;
    end else if (ptick && running) begin
      if (at_end) begin
        wrap_evt = 1'b1;
        if (ctrl.wd) begin
          cnt_nxt = ctrl.rsel ? cnt_q : load_q;
        end else if (ctrl.periodic) begin
          cnt_nxt = load_q;
        end else begin
          cnt_nxt = ctrl.up ? '0 : CNT_MAX;
        end
      end else begin
        cnt_nxt = ctrl.up && !ctrl.wd ? cnt_q + 1'b1 : cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end

  AST_WD_DEC: assert property (@(posedge clk) disable iff (rst)
    (ctrl.wd && ptick && !reload && !freeze && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R4

  AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
    freeze |=> $stable(cnt_q)); // R5

  AST_RELOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    (reload && !freeze) |=> (cnt_q == $past(reload_val))); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.wd && !ctrl.en && !reload) |=> $stable(cnt_q)); // R3
endmodule

// File: rtl/lockwd_timer.sv
module lockwd_timer
  import lockwd_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 8,
  parameter int MID_SH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_in,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq,
  output logic             rst_req
);
  logic [CNT_W-1:0] load_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload_val;
  ctrl_t            ctrl_q;
  logic             load_wr;
  logic             wd_enter;
  logic             clr_wr;
  logic             reload;
  logic             ptick;
  logic             wrap_evt;
  logic             to_reset;

  lockwd_regs #(.CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .cnt_val  (cnt_q),
    .load_q   (load_q),
    .ctrl_q   (ctrl_q),
    .rd_data  (rd_data),
    .load_wr  (load_wr),
    .wd_enter (wd_enter),
    .clr_wr   (clr_wr)
  );

  assign reload     = load_wr || wd_enter || clr_wr;
  assign reload_val = load_wr ? wr_data : load_q;

  lockwd_prescale #(.PRE_W(PRE_W), .MID_SH(MID_SH)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .tick_in (tick_in),
    .restart (reload),
    .psel    (ctrl_q.psel),
    .ptick   (ptick)
  );

  lockwd_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .ptick      (ptick),
    .reload     (reload),
    .reload_val (reload_val),
    .load_q     (load_q),
    .ctrl       (ctrl_q),
    .freeze     (rst_req),
    .cnt_q      (cnt_q),
    .wrap_evt   (wrap_evt)
  );

  assign to_reset = ctrl_q.wd && ctrl_q.rsel;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq     <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      if (clr_wr)                    irq <= 1'b0;
      else if (wrap_evt && !to_reset) irq <= 1'b1;
      if (wrap_evt && to_reset)      rst_req <= 1'b1;
    end
  end

  AST_RSTREQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> rst_req); // R5

  AST_CLR_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_CLEAR) |=> !irq); // R6

  AST_RSTREQ_ONLY_WD: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req) |-> ctrl_q.wd && ctrl_q.rsel); // R5
endmodule

// File: tb/lockwd_timer_tb.sv
`timescale 1ns/1ps
module lockwd_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_in = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [1:0]  rd_addr = 2'd0;
  logic [15:0] rd_data;
  logic        irq;
  logic        rst_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lockwd_timer u_dut (
    .clk(clk), .rst(rst), .tick_in(tick_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .rst_req(rst_req)
  );

  task automatic step(input logic t, input logic w, input logic [1:0] a, input logic [15:0] d);
    tick_in = t; wr_en = w; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    tick_in = 1'b0; wr_en = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    step(1'b0, 1'b1, a, d);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 2'd0, 16'd0);
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    rd_addr = a;
    step(1'b0, 1'b0, 2'd0, 16'd0);
    v = rd_data;
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(1'b0, 1'b0, 2'd0, 16'd0);
    step(1'b0, 1'b0, 2'd0, 16'd0);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [15:0] v0;
    int n;
    @(negedge clk);
    do_reset();

    // R1 reset state
    rd(2'd0, v); check("R1 load", v, 16'hFFFF);
    rd(2'd1, v); check("R1 value", v, 16'h0000);
    rd(2'd2, v); check("R1 ctrl", v, 16'h0000);
    check("R1 irq", {15'd0, irq}, 16'd0);
    check("R1 rst_req", {15'd0, rst_req}, 16'd0);
    rd(2'd3, v); check("R9 clear reads 0", v, 16'h0000);

    // R3 disabled counter holds, down free-running wrap
    wr(2'd0, 16'd3);
    rd(2'd1, v); check("R3 load copies to counter", v, 16'd3);
    ticks(4);
    rd(2'd1, v); check("R3 disabled holds", v, 16'd3);
    wr(2'd2, 16'h0010);
    rd(2'd2, v); check("R9 ctrl readback", v, 16'h0010);
    for (int k = 1; k <= 6; k++) begin
      ticks(1);
      rd(2'd1, v); check("R3 down free value", v, 16'(3 - k));
      check("R3 down free irq", {15'd0, irq}, (k >= 4) ? 16'd1 : 16'd0);
    end

    // R3 periodic down
    do_reset();
    wr(2'd0, 16'd4); wr(2'd2, 16'h0050);
    for (int k = 1; k <= 12; k++) begin
      ticks(1);
      rd(2'd1, v); check("R3 periodic down", v, 16'(4 - (k % 5)));
    end
    wr(2'd3, 16'h5A5A);
    check("R6 clear drops irq", {15'd0, irq}, 16'd0);

    // R3 up free and periodic
    do_reset();
    wr(2'd0, 16'hFFFD); wr(2'd2, 16'h0011);
    for (int k = 1; k <= 5; k++) begin
      ticks(1);
      rd(2'd1, v); check("R3 up free", v, 16'(16'hFFFD + k));
      check("R3 up irq", {15'd0, irq}, (k >= 3) ? 16'd1 : 16'd0);
    end
    do_reset();
    wr(2'd0, 16'hFFFE); wr(2'd2, 16'h0051);
    for (int k = 1; k <= 6; k++) begin
      ticks(1);
      rd(2'd1, v); check("R3 up periodic", v, 16'(16'hFFFE + (k % 2)));
    end

    // R2 prescale /16 and /256
    do_reset();
    wr(2'd0, 16'd10); wr(2'd2, 16'h0014);
    ticks(15); rd(2'd1, v); check("R2 div16 before", v, 16'd10);
    ticks(1);  rd(2'd1, v); check("R2 div16 step", v, 16'd9);
    ticks(16); rd(2'd1, v); check("R2 div16 second", v, 16'd8);
    do_reset();
    wr(2'd0, 16'd10); wr(2'd2, 16'h0018);
    ticks(255); rd(2'd1, v); check("R2 div256 before", v, 16'd10);
    ticks(1);   rd(2'd1, v); check("R2 div256 step", v, 16'd9);
    do_reset();
    wr(2'd0, 16'd10); wr(2'd2, 16'h001C);
    ticks(256); rd(2'd1, v); check("R2 psel11 step", v, 16'd9);

    // R2 R6 clear restarts the prescaler in watchdog mode
    do_reset();
    wr(2'd0, 16'd1); wr(2'd2, 16'h0024);
    ticks(10); wr(2'd3, 16'd0);
    ticks(15); rd(2'd1, v); check("R2 clear restarts prescaler", v, 16'd1);
    ticks(1);  rd(2'd1, v); check("R2 after restart", v, 16'd0);

    // R4 R5 watchdog interrupt sweep
    for (int L = 0; L <= 5; L++) begin
      do_reset();
      wr(2'd0, 16'(L)); wr(2'd2, 16'h0020);
      rd(2'd1, v); check("R4 entry copies load", v, 16'(L));
      n = 0;
      while (!irq && n < 300) begin ticks(1); n++; end
      check("R5 steps to expiry", 16'(n), 16'(L + 1));
      rd(2'd1, v); check("R5 reload after expiry", v, 16'(L));
      check("R5 no reset request", {15'd0, rst_req}, 16'd0);
      wr(2'd3, 16'hFFFF);
      check("R6 clear irq wd", {15'd0, irq}, 16'd0);
    end

    // R7 R8 lock and read-only value, then R6 coincident clear
    do_reset();
    wr(2'd0, 16'd2); wr(2'd2, 16'h0020);
    wr(2'd0, 16'd9); wr(2'd2, 16'h0000);
    rd(2'd0, v); check("R7 load locked", v, 16'd2);
    rd(2'd2, v); check("R7 ctrl locked", v, 16'h0020);
    rd(2'd1, v0); wr(2'd1, 16'h1234);
    rd(2'd1, v); check("R8 value write ignored", v, v0);
    ticks(2);
    rd(2'd1, v); check("R6 at zero", v, 16'd0);
    step(1'b1, 1'b1, 2'd3, 16'h00AA);
    check("R6 coincident no irq", {15'd0, irq}, 16'd0);
    rd(2'd1, v); check("R6 coincident reload", v, 16'd2);
    ticks(2); check("R6 period not yet", {15'd0, irq}, 16'd0);
    ticks(1); check("R6 new period expiry", {15'd0, irq}, 16'd1);

    // R5 reset-select
    do_reset();
    wr(2'd0, 16'd2); wr(2'd2, 16'h0022);
    ticks(2); check("R5 rst_req not yet", {15'd0, rst_req}, 16'd0);
    ticks(1); check("R5 rst_req raised", {15'd0, rst_req}, 16'd1);
    check("R5 irq untouched", {15'd0, irq}, 16'd0);
    wr(2'd3, 16'd0); ticks(5);
    check("R5 rst_req held", {15'd0, rst_req}, 16'd1);
    rd(2'd1, v); check("R5 counter frozen", v, 16'd0);
    do_reset();
    check("R1 rst clears rst_req", {15'd0, rst_req}, 16'd0);
    rd(2'd2, v); check("R7 rst leaves watchdog", v, 16'h0000);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule